// File: doc/BRIEF.md
# Cursor Overlay Pixel Mixer

This block places a small ARGB cursor image over the pixel stream of one display pipe. For every pixel it receives, together with that pixel's raster column and row, it works out whether a cursor texel lies over that spot. If one does, it fetches the texel from a local image RAM and mixes it over the background colour using the texel's alpha. The image RAM is loaded through a simple write port. The overlay setup comes in as already-armed register values that stay constant for the whole frame. These values are an enable, a size mode, a half-turn flag, a sign-magnitude position for each axis, and an optional shortened height.

The cursor is always square at 64, 128 or 256 pixels, unless a shortened height is armed. When the half-turn flag is set, texels are read starting from the last one and moving backwards. A negative position lets the cursor hang past the left or top edge of the screen. The result leaves the block exactly two clocks after the input, with its coordinates attached.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is asserted and in the first cycle after reset is released, `out_valid` is 0.
- R2: Each input pixel accepted with `in_valid`=1 at a clock edge appears at the outputs two edges later with `out_valid`=1 and the same `out_x`/`out_y`. No output appears without a matching input.
- R3: `cfg_mode` sets the width: 1 gives 64, 2 gives 128 and 3 gives 256. Mode 0, any mode from 4 to 7, or `cfg_enable`=0 means no cursor is drawn, and every pixel comes out equal to `in_pix`.
- R4: The cursor origin on each axis is `-mag` when the sign bit is 1 and `+mag` when it is 0. A pixel is covered when `origin_x <= x < origin_x+width` and `origin_y <= y < origin_y+height`, so parts of the cursor may lie left of column 0 or above row 0.
- R5: For a covered pixel, the linear texel index is `(y-origin_y)*width + (x-origin_x)`. The RAM word read is the index modulo the RAM depth (4096 words by default).
- R6: When `cfg_rot180`=1, the index used is `height*width-1` minus the R5 index.
- R7: When `cfg_short_en`=1 and `cfg_rot180`=0, the height is `cfg_short_hm1`+1. If that height is below 8 or above the width, the cursor is not drawn. When `cfg_rot180`=1, the short-height setting is ignored and the cursor is square.
- R8: A texel word holds alpha in [31:24] and red/green/blue in [23:16]/[15:8]/[7:0]. Pixels use the same RGB layout in 24 bits. Alpha 0 passes the background, alpha 255 gives the texel colour, and any other alpha gives `(t*a + b*(256-a)) >> 8` per channel.
- R9: `img_we`=1 writes `img_wdata` to word `img_waddr` at the clock edge. If the stream reads that same word at that same edge, it gets the old contents; later reads get the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel present |
| in_x | input | 12 | Raster column of the input pixel |
| in_y | input | 12 | Raster row of the input pixel |
| in_pix | input | 24 | Background RGB pixel |
| cfg_enable | input | 1 | Armed cursor enable |
| cfg_mode | input | 3 | Armed size mode (1/2/3 = 64/128/256) |
| cfg_rot180 | input | 1 | Armed half-turn flag |
| cfg_pos_x_neg | input | 1 | Sign of horizontal origin |
| cfg_pos_x_mag | input | 12 | Magnitude of horizontal origin |
| cfg_pos_y_neg | input | 1 | Sign of vertical origin |
| cfg_pos_y_mag | input | 12 | Magnitude of vertical origin |
| cfg_short_en | input | 1 | Shortened height enable |
| cfg_short_hm1 | input | 8 | Shortened height minus one |
| img_we | input | 1 | Image RAM write strobe |
| img_waddr | input | 12 | Image RAM write word address |
| img_wdata | input | 32 | Image RAM write data (ARGB) |
| out_valid | output | 1 | Output pixel present |
| out_x | output | 12 | Raster column of the output pixel |
| out_y | output | 12 | Raster row of the output pixel |
| out_pix | output | 24 | Mixed RGB pixel |

## Verification
The two activities that can land on the same edge are an image RAM write and the stream's texel fetch from that same word. The bench triggers this by sending a covered pixel whose texel word is written in that same cycle. It expects the old texel there. It then sends the same pixel again and expects the new texel. Every other output is compared against a reference computed inside the bench from the armed settings and the bench's own copy of the image.

// File: rtl/cur_pkg.sv
package cur_pkg;
  localparam int unsigned MAX_WLOG = 8;
  localparam int unsigned MIN_WLOG = 6;
  localparam int unsigned CH_W     = 8;
  localparam int unsigned NUM_CH   = 3;
  localparam int unsigned PIX_W    = CH_W * NUM_CH;
  localparam int unsigned TEX_W    = PIX_W + CH_W;

  localparam logic [2:0] MODE_W64  = 3'd1;
  localparam logic [2:0] MODE_W128 = 3'd2;
  localparam logic [2:0] MODE_W256 = 3'd3;

  typedef struct packed {
    logic [CH_W-1:0]  alpha;
    logic [PIX_W-1:0] rgb;
  } texel_t;
endpackage

// File: rtl/cur_size_decode.sv
module cur_size_decode
  import cur_pkg::*;
#(
  parameter int unsigned MIN_H = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_enable,
  input  logic [2:0]          cfg_mode,
  input  logic                cfg_rot180,
  input  logic                cfg_short_en,
  input  logic [MAX_WLOG-1:0] cfg_short_hm1,
  output logic                active,
  output logic [3:0]          wlog,
  output logic [MAX_WLOG:0]   width,
  output logic [MAX_WLOG:0]   height
);
  localparam int unsigned SW = MAX_WLOG + 1;

  logic mode_ok;
  logic h_ok;

  always_comb begin
    mode_ok = 1'b1;
    wlog    = 4'(MIN_WLOG);
    case (cfg_mode)
      MODE_W64:  wlog = 4'd6;
      MODE_W128: wlog = 4'd7;
      MODE_W256: wlog = 4'd8;
      default:   mode_ok = 1'b0;
    endcase
    width = SW'(1) << wlog;
    if (cfg_short_en && !cfg_rot180) begin
      height = {1'b0, cfg_short_hm1} + SW'(1);
      h_ok   = (height >= SW'(MIN_H)) && (height <= width);
    end else begin
      height = width;
      h_ok   = 1'b1;
    end
    active = cfg_enable && mode_ok && h_ok;
  end

  AST_HEIGHT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (height >= SW'(MIN_H) && height <= width && width >= SW'(64))); // R7
endmodule

// File: rtl/cur_geom.sv
module cur_geom
  import cur_pkg::*;
#(
  parameter int unsigned CW = 12,
  parameter int unsigned AW = 12
) (
  input  logic                x_valid,
  input  logic [CW-1:0]       x,
  input  logic [CW-1:0]       y,
  input  logic                pos_x_neg,
  input  logic [CW-1:0]       pos_x_mag,
  input  logic                pos_y_neg,
  input  logic [CW-1:0]       pos_y_mag,
  input  logic                rot180,
  input  logic                active,
  input  logic [3:0]          wlog,
  input  logic [MAX_WLOG:0]   width,
  input  logic [MAX_WLOG:0]   height,
  output logic                hit,
  output logic [AW-1:0]       addr
);
  localparam int unsigned RW = CW + 2;
  localparam int unsigned IW = 2 * MAX_WLOG + 1;
  localparam int unsigned SW = MAX_WLOG + 1;

  logic [RW-1:0] org_x, org_y, rel_x, rel_y;
  logic          in_x, in_y;
  logic [IW-1:0] idx_fwd, span, idx;

  always_comb begin
    org_x = pos_x_neg ? (RW'(0) - {2'b00, pos_x_mag}) : {2'b00, pos_x_mag};
    org_y = pos_y_neg ? (RW'(0) - {2'b00, pos_y_mag}) : {2'b00, pos_y_mag};
    rel_x = {2'b00, x} - org_x;
    rel_y = {2'b00, y} - org_y;
    in_x  = !rel_x[RW-1] && (rel_x < {{(RW-SW){1'b0}}, width});
    in_y  = !rel_y[RW-1] && (rel_y < {{(RW-SW){1'b0}}, height});
    hit   = x_valid && active && in_x && in_y;

    idx_fwd = ({{(IW-MAX_WLOG){1'b0}}, rel_y[MAX_WLOG-1:0]} << wlog)
            | {{(IW-MAX_WLOG){1'b0}}, rel_x[MAX_WLOG-1:0]};
    span    = {{(IW-SW){1'b0}}, height} << wlog;
    idx     = rot180 ? (span - IW'(1) - idx_fwd) : idx_fwd;
    addr    = idx[AW-1:0];
  end
endmodule

// File: rtl/cur_img_ram.sv
module cur_img_ram #(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/cur_blend.sv
module cur_blend
  import cur_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_hit,
  input  logic [CW-1:0]    in_x,
  input  logic [CW-1:0]    in_y,
  input  logic [PIX_W-1:0] in_bg,
  input  texel_t           texel,
  output logic             out_valid,
  output logic [CW-1:0]    out_x,
  output logic [CW-1:0]    out_y,
  output logic [PIX_W-1:0] out_pix
);
  localparam int unsigned AccW = 2 * CH_W + 1;

  logic [PIX_W-1:0] mix;
  logic [PIX_W-1:0] pix_nxt;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [AccW-1:0] acc;
    assign acc = AccW'(texel.rgb[ch*CH_W +: CH_W]) * AccW'(texel.alpha)
               + AccW'(in_bg[ch*CH_W +: CH_W]) * (AccW'(1 << CH_W) - AccW'(texel.alpha));
    assign mix[ch*CH_W +: CH_W] = acc[2*CH_W-1:CH_W];
  end

  always_comb begin
    if (!in_hit || texel.alpha == '0) begin
      pix_nxt = in_bg;
    end else if (texel.alpha == '1) begin
      pix_nxt = texel.rgb;
    end else begin
      pix_nxt = mix;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_x   <= in_x;
      out_y   <= in_y;
      out_pix <= pix_nxt;
    end
  end

  AST_OPAQUE_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_hit && texel.alpha == 8'hFF) |=> (out_pix == $past(texel.rgb))); // R8
  AST_CLEAR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (!in_hit || texel.alpha == 8'h00)) |=> (out_pix == $past(in_bg))); // R8
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cur_pkg::*;
#(
  parameter int unsigned CW        = 12,
  parameter int unsigned IMG_WORDS = 4096,
  localparam int unsigned AW       = $clog2(IMG_WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [CW-1:0]       in_x,
  input  logic [CW-1:0]       in_y,
  input  logic [PIX_W-1:0]    in_pix,
  input  logic                cfg_enable,
  input  logic [2:0]          cfg_mode,
  input  logic                cfg_rot180,
  input  logic                cfg_pos_x_neg,
  input  logic [CW-1:0]       cfg_pos_x_mag,
  input  logic                cfg_pos_y_neg,
  input  logic [CW-1:0]       cfg_pos_y_mag,
  input  logic                cfg_short_en,
  input  logic [MAX_WLOG-1:0] cfg_short_hm1,
  input  logic                img_we,
  input  logic [AW-1:0]       img_waddr,
  input  logic [TEX_W-1:0]    img_wdata,
  output logic                out_valid,
  output logic [CW-1:0]       out_x,
  output logic [CW-1:0]       out_y,
  output logic [PIX_W-1:0]    out_pix
);
  logic                cur_active;
  logic [3:0]          cur_wlog;
  logic [MAX_WLOG:0]   cur_width, cur_height;
  logic                hit;
  logic [AW-1:0]       raddr;
  logic [TEX_W-1:0]    tex_word;

  logic                s1_valid;
  logic                s1_hit;
  logic [CW-1:0]       s1_x, s1_y;
  logic [PIX_W-1:0]    s1_bg;

  cur_size_decode #(.MIN_H(8)) u_size (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_enable   (cfg_enable),
    .cfg_mode     (cfg_mode),
    .cfg_rot180   (cfg_rot180),
    .cfg_short_en (cfg_short_en),
    .cfg_short_hm1(cfg_short_hm1),
    .active       (cur_active),
    .wlog         (cur_wlog),
    .width        (cur_width),
    .height       (cur_height)
  );

  cur_geom #(.CW(CW), .AW(AW)) u_geom (
    .x_valid  (in_valid),
    .x        (in_x),
    .y        (in_y),
    .pos_x_neg(cfg_pos_x_neg),
    .pos_x_mag(cfg_pos_x_mag),
    .pos_y_neg(cfg_pos_y_neg),
    .pos_y_mag(cfg_pos_y_mag),
    .rot180   (cfg_rot180),
    .active   (cur_active),
    .wlog     (cur_wlog),
    .width    (cur_width),
    .height   (cur_height),
    .hit      (hit),
    .addr     (raddr)
  );

  cur_img_ram #(.DEPTH(IMG_WORDS), .DW(TEX_W)) u_ram (
    .clk  (clk),
    .we   (img_we),
    .waddr(img_waddr),
    .wdata(img_wdata),
    .re   (hit),
    .raddr(raddr),
    .rdata(tex_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_hit <= hit;
      s1_x   <= in_x;
      s1_y   <= in_y;
      s1_bg  <= in_pix;
    end
  end

  cur_blend #(.CW(CW)) u_blend (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (s1_valid),
    .in_hit   (s1_hit),
    .in_x     (s1_x),
    .in_y     (s1_y),
    .in_bg    (s1_bg),
    .texel    (texel_t'(tex_word)),
    .out_valid(out_valid),
    .out_x    (out_x),
    .out_y    (out_y),
    .out_pix  (out_pix)
  );

  AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid); // R2
  AST_COORD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 (out_x == $past(in_x, 2) && out_y == $past(in_y, 2))); // R2
  AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cur_active) |=> ##1 (out_pix == $past(in_pix, 2))); // R3
endmodule

// File: tb/test_cursor_overlay.sv
module test_cursor_overlay;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4096;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [11:0] in_x, in_y;
  logic [23:0] in_pix;
  logic        cfg_enable;
  logic [2:0]  cfg_mode;
  logic        cfg_rot180;
  logic        cfg_pos_x_neg, cfg_pos_y_neg;
  logic [11:0] cfg_pos_x_mag, cfg_pos_y_mag;
  logic        cfg_short_en;
  logic [7:0]  cfg_short_hm1;
  logic        img_we;
  logic [11:0] img_waddr;
  logic [31:0] img_wdata;
  logic        out_valid;
  logic [11:0] out_x, out_y;
  logic [23:0] out_pix;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [31:0] mirror [DEPTH];
  logic [47:0] exp_q [$];
  string       tag_q [$];
  int          cyc_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cursor_overlay i_cursor_overlay (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .in_pix(in_pix), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
    .cfg_rot180(cfg_rot180), .cfg_pos_x_neg(cfg_pos_x_neg),
    .cfg_pos_x_mag(cfg_pos_x_mag), .cfg_pos_y_neg(cfg_pos_y_neg),
    .cfg_pos_y_mag(cfg_pos_y_mag), .cfg_short_en(cfg_short_en),
    .cfg_short_hm1(cfg_short_hm1), .img_we(img_we), .img_waddr(img_waddr),
    .img_wdata(img_wdata), .out_valid(out_valid), .out_x(out_x),
    .out_y(out_y), .out_pix(out_pix)
  );

  function automatic logic [31:0] pattern(int i);
    logic [7:0] a;
    case (i % 4)
      0: a = 8'h00;
      1: a = 8'hFF;
      2: a = 8'h80;
      default: a = 8'((i * 7) + 1);
    endcase
    return {a, 8'(i) ^ 8'h5A, 8'(i >> 4), ~8'(i)};
  endfunction

  function automatic logic [23:0] bg_of(int x, int y);
    return {8'(x * 3), 8'(y * 5), 8'(x ^ y)};
  endfunction

  function automatic logic [23:0] model(int x, int y, logic [23:0] bg);
    int w, h, ox, oy, rx, ry, idx, a;
    logic [31:0] t;
    logic [23:0] r;
    if (!cfg_enable) return bg;
    case (cfg_mode)
      3'd1: w = 64;
      3'd2: w = 128;
      3'd3: w = 256;
      default: return bg;
    endcase
    h = w;
    if (cfg_short_en && !cfg_rot180) begin
      h = int'(cfg_short_hm1) + 1;
      if (h < 8 || h > w) return bg;
    end
    ox = cfg_pos_x_neg ? -int'(cfg_pos_x_mag) : int'(cfg_pos_x_mag);
    oy = cfg_pos_y_neg ? -int'(cfg_pos_y_mag) : int'(cfg_pos_y_mag);
    rx = x - ox;
    ry = y - oy;
    if (rx < 0 || rx >= w || ry < 0 || ry >= h) return bg;
    idx = ry * w + rx;
    if (cfg_rot180) idx = h * w - 1 - idx;
    t = mirror[idx % DEPTH];
    a = int'(t[31:24]);
    if (a == 0) return bg;
    if (a == 255) return t[23:0];
    for (int c = 0; c < 3; c++) begin
      r[c*8 +: 8] = 8'(((int'(t[c*8 +: 8]) * a) + (int'(bg[c*8 +: 8]) * (256 - a))) >> 8);
    end
    return r;
  endfunction

  task automatic px_w(input int x, input int y, input bit we, input int wa,
                      input logic [31:0] wd, input string tag);
    logic [23:0] bg;
    @(negedge clk);
    bg = bg_of(x, y);
    in_valid = 1'b1;
    in_x = 12'(x);
    in_y = 12'(y);
    in_pix = bg;
    img_we = we;
    img_waddr = 12'(wa);
    img_wdata = wd;
    exp_q.push_back({12'(x), 12'(y), model(x, y, bg)});
    tag_q.push_back(tag);
    cyc_q.push_back(cyc + 2);
    if (we) mirror[wa] = wd;
  endtask

  task automatic px(input int x, input int y, input string tag);
    px_w(x, y, 1'b0, 0, 32'h0, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      img_we = 1'b0;
    end
  endtask

  task automatic row(input int y, input int x0, input int x1, input string tag);
    for (int x = x0; x <= x1; x++) px(x, y, tag);
  endtask

  task automatic setup(input bit en, input logic [2:0] mode, input bit rot,
                       input bit xn, input int xm, input bit yn, input int ym,
                       input bit sh, input int hm1);
    idle(4);
    cfg_enable = en; cfg_mode = mode; cfg_rot180 = rot;
    cfg_pos_x_neg = xn; cfg_pos_x_mag = 12'(xm);
    cfg_pos_y_neg = yn; cfg_pos_y_mag = 12'(ym);
    cfg_short_en = sh; cfg_short_hm1 = 8'(hm1);
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R2 output without input: actual x=%0d y=%0d pix=%h expected none",
                 out_x, out_y, out_pix);
      end else begin
        logic [47:0] e;
        string t;
        int c;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        c = cyc_q.pop_front();
        if ({out_x, out_y, out_pix} !== e || cyc != c) begin
          failures++;
          $display("FAIL %s/R2: actual x=%0d y=%0d pix=%h cyc=%0d expected x=%0d y=%0d pix=%h cyc=%0d",
                   t, out_x, out_y, out_pix, cyc, e[47:36], e[35:24], e[23:0], c);
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
          failures++;
          $display("FAIL watchdog: actual running expected finished");
          $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
          $finish;
        end
      end
    join_none
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_x = '0; in_y = '0; in_pix = '0;
    img_we = 1'b0; img_waddr = '0; img_wdata = '0;
    cfg_enable = 1'b0; cfg_mode = 3'd0; cfg_rot180 = 1'b0;
    cfg_pos_x_neg = 1'b0; cfg_pos_x_mag = '0;
    cfg_pos_y_neg = 1'b0; cfg_pos_y_mag = '0;
    cfg_short_en = 1'b0; cfg_short_hm1 = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 during reset: actual %b expected 0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 after reset: actual %b expected 0", out_valid);
    end

    // R9 preload through the write port
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      img_we = 1'b1; img_waddr = 12'(i); img_wdata = pattern(i);
      mirror[i] = pattern(i);
    end
    idle(2);

    // R4 R5 R8: 64x64 at positive origin, edges and interior
    setup(1, 3'd1, 0, 0, 100, 0, 50, 0, 0);
    row(49, 98, 165, "R4");
    row(50, 98, 165, "R5/R8");
    row(80, 98, 165, "R8");
    row(113, 98, 165, "R4");
    row(114, 98, 165, "R4");

    // R4: negative origin hangs over left/top
    setup(1, 3'd1, 0, 1, 10, 1, 20, 0, 0);
    row(0, 0, 56, "R4");
    row(43, 0, 56, "R4");
    row(44, 0, 56, "R4");

    // R6: half turn
    setup(1, 3'd1, 1, 0, 100, 0, 50, 0, 0);
    row(50, 99, 164, "R6");
    row(113, 99, 164, "R6");

    // R7: short height 16, unrotated
    setup(1, 3'd1, 0, 0, 100, 0, 50, 1, 15);
    row(65, 99, 164, "R7");
    row(66, 99, 164, "R7");
    // R7: short height ignored when rotated
    setup(1, 3'd1, 1, 0, 100, 0, 50, 1, 15);
    row(100, 99, 164, "R7");
    // R7: heights 6 and 65 are illegal
    setup(1, 3'd1, 0, 0, 100, 0, 50, 1, 5);
    row(52, 99, 110, "R7");
    setup(1, 3'd1, 0, 0, 100, 0, 50, 1, 64);
    row(52, 99, 110, "R7");

    // R3 R5: wide modes with RAM index wrap
    setup(1, 3'd2, 0, 0, 0, 0, 0, 0, 0);
    row(40, 0, 130, "R3/R5");
    setup(1, 3'd3, 0, 0, 0, 0, 0, 0, 0);
    row(20, 250, 257, "R3/R5");

    // R3: disabled modes and enable low
    setup(1, 3'd0, 0, 0, 100, 0, 50, 0, 0);
    row(60, 100, 110, "R3");
    setup(1, 3'd5, 0, 0, 100, 0, 50, 0, 0);
    row(60, 100, 110, "R3");
    setup(1, 3'd7, 0, 0, 100, 0, 50, 0, 0);
    row(60, 100, 110, "R3");
    setup(0, 3'd1, 0, 0, 100, 0, 50, 0, 0);
    row(60, 100, 110, "R3");

    // R9: write and fetch of the same word in the same cycle
    setup(1, 3'd1, 0, 0, 0, 0, 0, 0, 0);
    px_w(5, 0, 1'b0, 0, 32'h0, "R9");
    px_w(5, 0, 1'b1, 5, 32'hFF12_3456, "R9");
    px(5, 0, "R9");
    px_w(6, 0, 1'b1, 6, 32'h40AB_CDEF, "R9");
    px(6, 0, "R9");
    idle(6);

    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R2 missing outputs: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule